// File: doc/BRIEF.md
# I2C Target Address Matcher

This block is the receive front end of an I2C target. It oversamples the open-drain SCL and SDA lines in the system clock domain, passes both through a synchronizer, and finds START and STOP conditions from SDA edges seen while SCL is high. After a START it collects the address phase and compares it with a configured address. Both the single-byte 7-bit form and the two-byte 10-bit form are supported, chosen by a static configuration input.

When the address matches, the target acknowledges by pulling SDA low for the ninth clock. When it does not match, the target goes silent and stays silent until the bus shows a STOP. After a write-direction match, every following byte is presented on a one-cycle byte strobe and acknowledged. After a read-direction match, the target acknowledges the address and then releases the bus until STOP. The only thing the block ever does to the bus is pull SDA low. It never drives a line high.

Top module: `i2cAddrMatch`

## Requirements
- R1: After reset, sdaPullLow, rxValid and addrHit are all 0.
- R2: In 7-bit mode, an address byte whose bits 7:1 equal cfgAddr[6:0] and whose bit 0 (direction, 0 = write) is 0 is acknowledged, meaning SDA is low during the ninth SCL high phase. addrHit pulses for one cycle with addrRead = 0.
- R3: In 7-bit mode, a non-matching address byte is not acknowledged. No later byte is acknowledged and rxValid stays 0 until a STOP.
- R4: After a mismatch, a repeated START is ignored. A matching address sent after it is not acknowledged until a STOP has been seen.
- R5: In 10-bit mode, a first byte of the form 11110 a9 a8 0 is acknowledged when a9:a8 equal cfgAddr[9:8]. The second byte is acknowledged only when it equals cfgAddr[7:0], and only then does addrHit pulse, with addrRead = 0.
- R6: In 10-bit mode, a first byte with the wrong upper bits, or a second byte that differs from cfgAddr[7:0], is not acknowledged. No data byte after it is acknowledged or delivered.
- R7: After a write-direction match, each byte that follows is received MSB first. It appears on rxData with a single-cycle rxValid pulse and is acknowledged.
- R8: In 7-bit mode, a matching address with bit 0 = 1 (read) is acknowledged and gives addrHit with addrRead = 1. The bytes that follow are neither acknowledged nor delivered on rxValid.
- R9: sdaPullLow changes only while the synchronized SCL is low. In particular, it is not asserted during the eighth SCL high phase of a byte.
- R10: A STOP returns the target to idle, so the next START with a matching address is acknowledged again.
- R11: In 10-bit mode, a first byte without the 11110 prefix is not acknowledged, even when its upper seven bits equal cfgAddr[6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| cfgTenBit | input | 1 | 1 selects two-byte 10-bit addressing, 0 selects 7-bit |
| cfgAddr | input | 10 | Own address; only bits 6:0 are used in 7-bit mode |
| sdaPullLow | output | 1 | 1 pulls SDA low through the open-drain pad |
| rxValid | output | 1 | One-cycle strobe marking a received data byte |
| rxData | output | 8 | Last received data byte, valid with rxValid |
| addrHit | output | 1 | One-cycle strobe when the full address has matched |
| addrRead | output | 1 | Direction of the matched transfer, 1 = read |

## Verification
Two events can fall in the same SCL low phase. One is the target releasing its acknowledge after the ninth clock falls. The other is the controller driving the first bit of the next byte or the STOP setup. The bench provokes this by changing SDA immediately after each falling SCL while the target's pull is still active. It then judges the result by the next byte's acknowledge, the delivered rxData values, and by whether the STOP and START were detected correctly. A second overlap comes from a repeated START arriving while the target is ignoring a mismatched transfer. Start detection competes with the rule to wait for STOP. The bench sends a matching address right after such a START and expects no acknowledge, and then expects one after a proper STOP.

// File: rtl/i2cAddrPkg.sv
package i2cAddrPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_ARM,
    ST_ACK,
    ST_DATA,
    ST_SKIP
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic clrCnt;
    logic setAck;
    logic relAck;
    logic byteOut;
    logic hitOut;
    logic hitRead;
  } ctrlStrb_t;

  // conditions reported by datapath to control
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclFall;
    logic byteRdy;
    logic hit7;
    logic read7;
    logic hit10Hi;
    logic hit10Lo;
  } dpStat_t;

endpackage

// File: rtl/i2cAddrDp.sv
module i2cAddrDp
  import i2cAddrPkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  ctrlStrb_t         strb,
  output dpStat_t           stat,
  output logic              sclSync,
  output logic              sdaPullLow,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              addrHit,
  output logic              addrRead
);

  localparam int          CNT_W   = $clog2(BYTE_W);
  localparam int          HI_W    = ADDR_W - BYTE_W;
  localparam int          TAG_W   = 5;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [TAG_W-1:0] TEN_TAG  = 5'b11110;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclPrev, sdaPrev;
  logic                   sclS, sdaS;
  logic                   sclRise;
  logic [BYTE_W-1:0]      shiftReg;
  logic [CNT_W-1:0]       bitCnt;
  logic                   byteRdyQ;

  // bus idles high, so the synchronizer resets to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclSync = sclS;
  assign sclRise = sclS & ~sclPrev;

  // bit collection, MSB first, one bit per rising SCL
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      byteRdyQ  <= 1'b0;
    end else begin
      byteRdyQ <= 1'b0;
      if (strb.clrCnt) begin
        bitCnt <= '0;
      end else if (strb.shiftEn && sclRise) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
        if (bitCnt == LAST_BIT) begin
          bitCnt   <= '0;
          byteRdyQ <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // acknowledge driver: only ever pulls low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaPullLow <= 1'b0;
    end else if (strb.relAck) begin
      sdaPullLow <= 1'b0;
    end else if (strb.setAck) begin
      sdaPullLow <= 1'b1;
    end
  end

  // byte and address strobes toward the client
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid  <= 1'b0;
      rxData   <= '0;
      addrHit  <= 1'b0;
      addrRead <= 1'b0;
    end else begin
      rxValid <= strb.byteOut;
      addrHit <= strb.hitOut;
      if (strb.byteOut) rxData   <= shiftReg;
      if (strb.hitOut)  addrRead <= strb.hitRead;
    end
  end

  always_comb begin
    stat          = '0;
    stat.startDet = sclS & sclPrev & sdaPrev & ~sdaS;
    stat.stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
    stat.sclFall  = ~sclS & sclPrev;
    stat.byteRdy  = byteRdyQ;
    stat.hit7     = (shiftReg[BYTE_W-1:1] == cfgAddr[BYTE_W-2:0]);
    stat.read7    = shiftReg[0];
    stat.hit10Hi  = (shiftReg[BYTE_W-1 -: TAG_W] == TEN_TAG) &&
                    (shiftReg[HI_W:1] == cfgAddr[ADDR_W-1 -: HI_W]) &&
                    !shiftReg[0];
    stat.hit10Lo  = (shiftReg == cfgAddr[BYTE_W-1:0]);
  end

endmodule

// File: rtl/i2cAddrCtl.sv
module i2cAddrCtl
  import i2cAddrPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgTenBit,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      inSkip
);

  tgtState_e state, stateNxt;
  tgtState_e afterAck, afterAckNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
    end else begin
      state    <= stateNxt;
      afterAck <= afterAckNxt;
    end
  end

  always_comb begin
    strb        = '0;
    stateNxt    = state;
    afterAckNxt = afterAck;
    if (stat.startDet && state != ST_SKIP) begin
      // START or repeated START opens a new address phase
      stateNxt     = ST_ADDR_HI;
      strb.clrCnt  = 1'b1;
      strb.relAck  = 1'b1;
    end else if (stat.stopDet) begin
      stateNxt     = ST_IDLE;
      strb.clrCnt  = 1'b1;
      strb.relAck  = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR_HI: begin
          strb.shiftEn = 1'b1;
          if (stat.byteRdy) begin
            if (cfgTenBit) begin
              if (stat.hit10Hi) begin
                stateNxt    = ST_ARM;
                afterAckNxt = ST_ADDR_LO;
              end else begin
                stateNxt = ST_SKIP;
              end
            end else if (stat.hit7) begin
              stateNxt     = ST_ARM;
              strb.hitOut  = 1'b1;
              strb.hitRead = stat.read7;
              afterAckNxt  = stat.read7 ? ST_SKIP : ST_DATA;
            end else begin
              stateNxt = ST_SKIP;
            end
          end
        end
        ST_ADDR_LO: begin
          strb.shiftEn = 1'b1;
          if (stat.byteRdy) begin
            if (stat.hit10Lo) begin
              stateNxt    = ST_ARM;
              strb.hitOut = 1'b1;
              afterAckNxt = ST_DATA;
            end else begin
              stateNxt = ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          strb.shiftEn = 1'b1;
          if (stat.byteRdy) begin
            stateNxt     = ST_ARM;
            strb.byteOut = 1'b1;
            afterAckNxt  = ST_DATA;
          end
        end
        ST_ARM: begin
          if (stat.sclFall) begin
            strb.setAck = 1'b1;
            stateNxt    = ST_ACK;
          end
        end
        ST_ACK: begin
          if (stat.sclFall) begin
            strb.relAck = 1'b1;
            strb.clrCnt = 1'b1;
            stateNxt    = afterAck;
          end
        end
        default: ;
      endcase
    end
  end

  assign inSkip = (state == ST_SKIP);

endmodule

// File: rtl/i2cAddrMatch.sv
module i2cAddrMatch
  import i2cAddrPkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              cfgTenBit,
  input  logic [ADDR_W-1:0] cfgAddr,
  output logic              sdaPullLow,
  output logic              rxValid,
  output logic [BYTE_W-1:0] rxData,
  output logic              addrHit,
  output logic              addrRead
);

  ctrlStrb_t strb;
  dpStat_t   stat;
  logic      sclSync;
  logic      inSkip;

  i2cAddrDp #(
    .BYTE_W     (BYTE_W),
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .cfgAddr   (cfgAddr),
    .strb      (strb),
    .stat      (stat),
    .sclSync   (sclSync),
    .sdaPullLow(sdaPullLow),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .addrHit   (addrHit),
    .addrRead  (addrRead)
  );

  i2cAddrCtl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgTenBit(cfgTenBit),
    .stat     (stat),
    .strb     (strb),
    .inSkip   (inSkip)
  );

endmodule

// File: rtl/i2cAddrMatchChk.sv
module i2cAddrMatchChk (
  input logic clk,
  input logic rstN,
  input logic sclSync,
  input logic sdaPullLow,
  input logic rxValid,
  input logic addrHit,
  input logic addrRead,
  input logic cfgTenBit,
  input logic inSkip
);

  // R9: the acknowledge pull moves only while SCL is low
  a_r9_pull_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaPullLow) |-> !sclSync);

  // R7: each data byte produces a single-cycle strobe
  a_r7_rx_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R2: address hit is a single-cycle strobe
  a_r2_hit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    addrHit |=> !addrHit);

  // R3: while ignoring the bus nothing is pulled or delivered
  a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rstN)
    inSkip |-> (!sdaPullLow && !rxValid && !addrHit));

  // R5: a 10-bit hit is always write direction
  a_r5_ten_write: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && cfgTenBit) |-> !addrRead);

endmodule

bind i2cAddrMatch i2cAddrMatchChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclSync   (sclSync),
  .sdaPullLow(sdaPullLow),
  .rxValid   (rxValid),
  .addrHit   (addrHit),
  .addrRead  (addrRead),
  .cfgTenBit (cfgTenBit),
  .inSkip    (inSkip)
);

// File: tb/i2cAddrMatch_tb.sv
module i2cAddrMatch_tb;

  localparam int Q = 20;

  typedef struct packed {
    logic       ten;
    logic [9:0] cfg;
    logic       two;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] dat;
    logic       expA0;
    logic       expA1;
    logic       expD;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h02A, 1'b0, 8'h54, 8'h00, 8'hA5, 1'b1, 1'b0, 1'b1}, // R2 R7
    '{1'b0, 10'h02A, 1'b0, 8'h56, 8'h00, 8'h33, 1'b0, 1'b0, 1'b0}, // R3
    '{1'b1, 10'h2C7, 1'b1, 8'hF4, 8'hC7, 8'h3C, 1'b1, 1'b1, 1'b1}, // R5
    '{1'b1, 10'h2C7, 1'b1, 8'hF4, 8'hC6, 8'h3C, 1'b1, 1'b0, 1'b0}, // R6
    '{1'b1, 10'h2C7, 1'b1, 8'hF2, 8'hC7, 8'h3C, 1'b0, 1'b0, 1'b0}, // R6
    '{1'b0, 10'h07F, 1'b0, 8'hFE, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1}, // R2
    '{1'b1, 10'h054, 1'b0, 8'hA8, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0}  // R11
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclDrv = 1'b1;
  logic       sdaDrv = 1'b1;
  logic       cfgTenBit = 1'b0;
  logic [9:0] cfgAddr = '0;
  logic       sdaPullLow, rxValid, addrHit, addrRead;
  logic [7:0] rxData;
  logic       sdaBus;

  int nCheck = 0;
  int nFail  = 0;
  int rxCnt  = 0;
  int hitCnt = 0;
  logic [7:0] lastRx = '0;
  logic       lastRead = 1'b0;

  always #5 clk = ~clk;

  assign sdaBus = sdaDrv & ~sdaPullLow;

  i2cAddrMatch u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclDrv),
    .sdaIn     (sdaBus),
    .cfgTenBit (cfgTenBit),
    .cfgAddr   (cfgAddr),
    .sdaPullLow(sdaPullLow),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .addrHit   (addrHit),
    .addrRead  (addrRead)
  );

  always @(negedge clk) begin
    if (rstN && rxValid) begin
      rxCnt  = rxCnt + 1;
      lastRx = rxData;
    end
    if (rstN && addrHit) begin
      hitCnt   = hitCnt + 1;
      lastRead = addrRead;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitN(Q);
    sclDrv = 1'b1; waitN(Q);
    sdaDrv = 1'b0; waitN(Q);
    sclDrv = 1'b0; waitN(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitN(Q);
    sclDrv = 1'b1; waitN(Q);
    sdaDrv = 1'b1; waitN(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack, output logic early);
    early = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitN(Q);
      sclDrv = 1'b1; waitN(Q);
      if (i == 0) early = sdaPullLow;
      sclDrv = 1'b0;
    end
    sdaDrv = 1'b1; waitN(Q);
    sclDrv = 1'b1; waitN(Q / 2);
    ack = ~sdaBus;
    waitN(Q / 2);
    sclDrv = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCheck++;
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
    $finish;
  end

  initial begin
    logic ack, early;
    int   rx0, hit0;

    waitN(4);
    // R1: reset state
    check(sdaPullLow == 1'b0, "R1 sdaPullLow", sdaPullLow, 0);
    check(rxValid == 1'b0,    "R1 rxValid",    rxValid,    0);
    check(addrHit == 1'b0,    "R1 addrHit",    addrHit,    0);
    rstN = 1'b1;
    waitN(4);

    // vector table
    for (int v = 0; v < NV; v++) begin
      cfgTenBit = VECS[v].ten;
      cfgAddr   = VECS[v].cfg;
      rx0  = rxCnt;
      hit0 = hitCnt;
      busStart();
      sendByte(VECS[v].b0, ack, early);
      check(ack == VECS[v].expA0, $sformatf("R2/R3/R5/R11 vec%0d first ack", v), ack, VECS[v].expA0);
      if (VECS[v].two) begin
        sendByte(VECS[v].b1, ack, early);
        check(ack == VECS[v].expA1, $sformatf("R5/R6 vec%0d second ack", v), ack, VECS[v].expA1);
      end
      sendByte(VECS[v].dat, ack, early);
      check(ack == VECS[v].expD, $sformatf("R7/R3/R6 vec%0d data ack", v), ack, VECS[v].expD);
      check((rxCnt - rx0) == int'(VECS[v].expD), $sformatf("R7 vec%0d rx count", v), rxCnt - rx0, VECS[v].expD);
      if (VECS[v].expD)
        check(lastRx == VECS[v].dat, $sformatf("R7 vec%0d rxData", v), lastRx, VECS[v].dat);
      check((hitCnt - hit0) == int'(VECS[v].two ? VECS[v].expA1 : VECS[v].expA0),
            $sformatf("R2/R5 vec%0d hit count", v), hitCnt - hit0,
            VECS[v].two ? VECS[v].expA1 : VECS[v].expA0);
      if (hitCnt != hit0)
        check(lastRead == 1'b0, $sformatf("R2 vec%0d addrRead", v), lastRead, 0);
      busStop();
    end

    // R8: read-direction match
    cfgTenBit = 1'b0;
    cfgAddr   = 10'h02A;
    rx0  = rxCnt;
    hit0 = hitCnt;
    busStart();
    sendByte(8'h55, ack, early);
    check(ack == 1'b1, "R8 read address ack", ack, 1);
    check(hitCnt - hit0 == 1, "R8 hit count", hitCnt - hit0, 1);
    check(lastRead == 1'b1, "R8 addrRead", lastRead, 1);
    sendByte(8'hFF, ack, early);
    check(ack == 1'b0, "R8 no ack after read", ack, 0);
    check(rxCnt == rx0, "R8 no rx after read", rxCnt - rx0, 0);
    busStop();

    // R4: repeated START while ignoring, then R10 after STOP
    busStart();
    sendByte(8'h12, ack, early);
    check(ack == 1'b0, "R3 mismatch no ack", ack, 0);
    busStart();
    sendByte(8'h54, ack, early);
    check(ack == 1'b0, "R4 repeated START ignored", ack, 0);
    busStop();
    busStart();
    sendByte(8'h54, ack, early);
    check(ack == 1'b1, "R10 ack after STOP", ack, 1);
    busStop();

    // R7 multi-byte burst with R9 early-pull check
    rx0 = rxCnt;
    busStart();
    sendByte(8'h54, ack, early);
    check(ack == 1'b1, "R2 burst address ack", ack, 1);
    check(early == 1'b0, "R9 no pull in eighth SCL high", early, 0);
    sendByte(8'h81, ack, early);
    check(ack == 1'b1 && lastRx == 8'h81, "R7 burst byte0", lastRx, 8'h81);
    check(early == 1'b0, "R9 no pull in data eighth high", early, 0);
    sendByte(8'h7E, ack, early);
    check(ack == 1'b1 && lastRx == 8'h7E, "R7 burst byte1", lastRx, 8'h7E);
    sendByte(8'h5A, ack, early);
    check(ack == 1'b1 && lastRx == 8'h5A, "R7 burst byte2", lastRx, 8'h5A);
    check(rxCnt - rx0 == 3, "R7 burst count", rxCnt - rx0, 3);
    busStop();
    waitN(8);
    check(sdaPullLow == 1'b0, "R9 released after STOP", sdaPullLow, 0);

    $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
    $finish;
  end

endmodule